// File: doc/BRIEF.md
# Grouped-Priority Interrupt Arbiter

This block chooses which of a set of interrupt sources the core is asked to serve next. Every source has an enable, a pending flag and a priority value. A global grouping code splits that value into two parts. The upper part is a preemption level and the lower part is a sub-level. The full value orders the pending candidates. Only the preemption part decides whether a candidate may interrupt the handler that is already running.

The block keeps a nesting stack with one entry per running handler. Each entry holds the handler's preemption level and source number. An acknowledge from the core moves the current winner from pending to active and pushes its entry. An end-of-service pops the newest entry and retires that source. The outputs are the request line, the winning source number and the preemption level in force.

Top module: `gpi_arbiter`

## Requirements
- R1: Out of reset no source is pending or active, `irq_req` is 0, `irq_id` is 0 and `run_level` shows the idle value.
- R2: A one-cycle pulse on `irq_set[i]` makes source i pending. It stays pending until it is acknowledged. Only a source that is pending, enabled and not active is a candidate, and clearing its enable keeps it pending.
- R3: Each source owns an 8-bit field in `src_prio`, where source i occupies bits [8i+7:8i]. Only the upper 4 bits of the field form the priority value, and the lower 4 bits have no effect.
- R4: Among the candidates, the one with the numerically smallest 4-bit priority value wins. This is the same as comparing the preemption part first and then the sub-part.
- R5: When candidates have equal priority values, the one that became pending in an earlier cycle wins. If they became pending in the same cycle, the lower source number wins.
- R6: The grouping code g on `group_sel` gives min(7-g, 4) preemption bits, taken as the upper bits of the priority value. So 7 gives 0 bits, 6 gives 1, 5 gives 2, 4 gives 3, and 0 to 3 give 4.
- R7: `irq_req` is 1 only when a winner exists and its preemption level is numerically smaller than `run_level`. A difference in sub-level alone never raises `irq_req`.
- R8: With no active handler, `run_level` equals 16, which is one below the least urgent level. Any candidate is then requested.
- R9: `ack` while `irq_req` is 1 and `eoi` is 0 clears the winner's pending flag, marks it active and pushes its preemption level, which then appears on `run_level`. `ack` while `irq_req` is 0 is ignored.
- R10: `eoi` pops the newest stack entry, retires that source and restores the previous `run_level`. `eoi` with an empty stack changes nothing. When `ack` and `eoi` arrive in the same cycle, `ack` is ignored.
- R11: An active source is never selected until its entry is popped. It may be set pending again while it is active.
- R12: `irq_id` shows the winning candidate's number whenever one exists, even when it cannot preempt, and shows 0 when there is none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_en | input | 60 | Per-source enable |
| src_prio | input | 480 | Per-source 8-bit priority fields; upper nibble used |
| group_sel | input | 3 | Grouping code that sets the preemption/sub split |
| irq_set | input | 60 | Per-source pulse that marks a request pending |
| ack | input | 1 | Core takes the current winner |
| eoi | input | 1 | Core finishes the newest active handler |
| irq_req | output | 1 | Request to the core |
| irq_id | output | 6 | Winning source number |
| run_level | output | 5 | Preemption level in force; 16 when idle |

## Verification
The assertions take for granted that the grouping code does not change while any handler is active. Under that condition the pushed levels strictly rise in urgency up the stack, so every pop makes `run_level` larger. They also assume that no request waits pending through 65536 cycles in which new arrivals occur, because arrival order is kept in a wrapping stamp. The stimulus drains the stack and all pending work before it changes `group_sel`. The run is short enough that the arrival count never comes near the stamp range.

// File: rtl/gpi_pkg.sv
package gpi_pkg;

    localparam int FIELD_W = 8;
    localparam int GRP_W   = 3;

    // Number of preemption bits selected by a grouping code.
    function automatic int preempt_width(input logic [GRP_W-1:0] grp, input int pbits);
        int w;
        w = 7 - int'(grp);
        if (w > pbits) w = pbits;
        return w;
    endfunction

endpackage

// File: rtl/gpi_pick.sv
module gpi_pick #(
    parameter int N     = 60,
    parameter int PB    = 4,
    parameter int ID_W  = 6,
    parameter int AGE_W = 16
) (
    input  logic [N-1:0]            cand,
    input  logic [N-1:0][PB-1:0]    nib,
    input  logic [N-1:0][AGE_W-1:0] age,
    output logic                    found,
    output logic [ID_W-1:0]         win_id,
    output logic [PB-1:0]           win_nib
);

    logic [AGE_W-1:0] best_age;

    // Linear scan: a later source replaces the best only when strictly better,
    // so equal value and equal age leave the lower number in place.
    always_comb begin
        found    = 1'b0;
        win_id   = '0;
        win_nib  = '0;
        best_age = '0;
        for (int i = 0; i < N; i++) begin
            if (cand[i]) begin
                if (!found || (nib[i] < win_nib) ||
                    ((nib[i] == win_nib) && (age[i] > best_age))) begin
                    found    = 1'b1;
                    win_id   = ID_W'(i);
                    win_nib  = nib[i];
                    best_age = age[i];
                end
            end
        end
    end

endmodule

// File: rtl/gpi_nest.sv
module gpi_nest #(
    parameter int DEPTH = 16,
    parameter int LVL_W = 4,
    parameter int ID_W  = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [LVL_W-1:0] push_lvl,
    input  logic [ID_W-1:0]  push_id,
    input  logic             pop,
    output logic [LVL_W:0]   top_lvl,
    output logic [ID_W-1:0]  top_id,
    output logic             empty
);

    localparam int SP_W = $clog2(DEPTH + 1);
    localparam int IX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    typedef struct packed {
        logic [SP_W-1:0]              sp;
        logic [DEPTH-1:0][LVL_W-1:0]  lvl;
        logic [DEPTH-1:0][ID_W-1:0]   id;
    } nest_t;

    nest_t nest_d, nest_q;
    logic [SP_W-1:0] top_ix;

    always_comb begin
        top_ix = nest_q.sp - 1'b1;
        empty  = (nest_q.sp == '0);
        top_id = nest_q.id[top_ix[IX_W-1:0]];
        if (empty) top_lvl = {1'b1, {LVL_W{1'b0}}};
        else       top_lvl = {1'b0, nest_q.lvl[top_ix[IX_W-1:0]]};
    end

    always_comb begin
        nest_d = nest_q;
        if (pop && !empty) begin
            nest_d.sp = nest_q.sp - 1'b1;
        end else if (push && (nest_q.sp != SP_W'(DEPTH))) begin
            nest_d.lvl[nest_q.sp[IX_W-1:0]] = push_lvl;
            nest_d.id[nest_q.sp[IX_W-1:0]]  = push_id;
            nest_d.sp = nest_q.sp + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) nest_q <= '0;
        else        nest_q <= nest_d;
    end

endmodule

// File: rtl/gpi_arbiter.sv
module gpi_arbiter #(
    parameter int NUM_SRC   = 60,
    parameter int PRIO_BITS = 4,
    parameter int STAMP_W   = 16
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic [NUM_SRC-1:0]                    src_en,
    input  logic [NUM_SRC*gpi_pkg::FIELD_W-1:0]   src_prio,
    input  logic [gpi_pkg::GRP_W-1:0]             group_sel,
    input  logic [NUM_SRC-1:0]                    irq_set,
    input  logic                                  ack,
    input  logic                                  eoi,
    output logic                                  irq_req,
    output logic [$clog2(NUM_SRC)-1:0]            irq_id,
    output logic [PRIO_BITS:0]                    run_level
);

    localparam int ID_W    = $clog2(NUM_SRC);
    localparam int FIELD_W = gpi_pkg::FIELD_W;
    localparam int DEPTH   = 1 << PRIO_BITS;
    localparam int LOW_W   = FIELD_W - PRIO_BITS;

    typedef struct packed {
        logic [NUM_SRC-1:0]              pend;
        logic [NUM_SRC-1:0]              act;
        logic [NUM_SRC-1:0][STAMP_W-1:0] stamp;
        logic [STAMP_W-1:0]              cnt;
    } arb_t;

    arb_t st_d, st_q;

    logic [NUM_SRC-1:0][PRIO_BITS-1:0] nib;
    logic [NUM_SRC-1:0][STAMP_W-1:0]   age;
    logic [NUM_SRC-1:0]                cand;
    logic [NUM_SRC-1:0]                unused_low_bits;
    logic                              found;
    logic [ID_W-1:0]                   win_id;
    logic [PRIO_BITS-1:0]              win_nib;
    logic [PRIO_BITS-1:0]              win_pre;
    logic [ID_W-1:0]                   top_id;
    logic                              stk_empty;
    logic                              do_push;
    logic                              do_pop;
    int                                np;

    // Per-source field slicing; the low part of each field is discarded.
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        assign nib[g]  = src_prio[g*FIELD_W + LOW_W +: PRIO_BITS];
        assign unused_low_bits[g] = ^src_prio[g*FIELD_W +: LOW_W];
        assign age[g]  = st_q.cnt - st_q.stamp[g];
        assign cand[g] = st_q.pend[g] & src_en[g] & ~st_q.act[g];
    end

    gpi_pick #(
        .N     (NUM_SRC),
        .PB    (PRIO_BITS),
        .ID_W  (ID_W),
        .AGE_W (STAMP_W)
    ) pick_i (
        .cand    (cand),
        .nib     (nib),
        .age     (age),
        .found   (found),
        .win_id  (win_id),
        .win_nib (win_nib)
    );

    always_comb begin
        np      = gpi_pkg::preempt_width(group_sel, PRIO_BITS);
        win_pre = PRIO_BITS'(win_nib >> (PRIO_BITS - np));
        irq_req = found && ({1'b0, win_pre} < run_level);
        irq_id  = win_id;
        do_pop  = eoi && !stk_empty;
        do_push = ack && irq_req && !eoi;
    end

    gpi_nest #(
        .DEPTH (DEPTH),
        .LVL_W (PRIO_BITS),
        .ID_W  (ID_W)
    ) nest_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (do_push),
        .push_lvl (win_pre),
        .push_id  (win_id),
        .pop      (do_pop),
        .top_lvl  (run_level),
        .top_id   (top_id),
        .empty    (stk_empty)
    );

    always_comb begin
        logic any_new;
        st_d    = st_q;
        any_new = 1'b0;
        if (do_push) begin
            st_d.pend[win_id] = 1'b0;
            st_d.act[win_id]  = 1'b1;
        end
        if (do_pop) begin
            st_d.act[top_id] = 1'b0;
        end
        for (int i = 0; i < NUM_SRC; i++) begin
            if (irq_set[i] && !st_d.pend[i]) begin
                st_d.pend[i]  = 1'b1;
                st_d.stamp[i] = st_q.cnt;
                any_new       = 1'b1;
            end
        end
        if (any_new) st_d.cnt = st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/gpi_arbiter_chk.sv
module gpi_arbiter_chk #(
    parameter int PB   = 4,
    parameter int ID_W = 6
) (
    input logic            clk,
    input logic            rst_n,
    input logic            ack,
    input logic            eoi,
    input logic            irq_req,
    input logic [ID_W-1:0] irq_id,
    input logic [PB:0]     run_level
);

    localparam logic [PB:0] IDLE_LVL = {1'b1, {PB{1'b0}}};

    AST_PUSH_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && irq_req && !eoi) |=> (run_level < $past(run_level))); // R9

    AST_IGNORED_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !irq_req && !eoi) |=> (run_level == $past(run_level))); // R9

    AST_NO_REPICK: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && irq_req && !eoi) |=> (!irq_req || (irq_id != $past(irq_id)))); // R11

    AST_POP_LOWERS: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi && (run_level != IDLE_LVL)) |=> (run_level > $past(run_level))); // R10

    AST_EMPTY_EOI: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi && (run_level == IDLE_LVL)) |=> (run_level == IDLE_LVL)); // R10

    AST_REQ_NEEDS_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (run_level != '0)); // R7

    AST_LEVEL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        run_level <= IDLE_LVL); // R8

endmodule

bind gpi_arbiter gpi_arbiter_chk #(
    .PB   (PRIO_BITS),
    .ID_W (ID_W)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .ack       (ack),
    .eoi       (eoi),
    .irq_req   (irq_req),
    .irq_id    (irq_id),
    .run_level (run_level)
);

// File: tb/gpi_arbiter_tb_top.sv
`timescale 1ns/1ps
module gpi_arbiter_tb_top;

    localparam int N = 60;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [N-1:0]   src_en = '0;
    logic [N*8-1:0] src_prio;
    logic [2:0]     group_sel = 3'd3;
    logic [N-1:0]   irq_set = '0;
    logic           ack = 1'b0;
    logic           eoi = 1'b0;
    logic           irq_req;
    logic [5:0]     irq_id;
    logic [4:0]     run_level;

    logic [7:0] prio_b [N];

    always #2 clk = ~clk;

    always_comb begin
        for (int i = 0; i < N; i++) src_prio[i*8 +: 8] = prio_b[i];
    end

    gpi_arbiter dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_en    (src_en),
        .src_prio  (src_prio),
        .group_sel (group_sel),
        .irq_set   (irq_set),
        .ack       (ack),
        .eoi       (eoi),
        .irq_req   (irq_req),
        .irq_id    (irq_id),
        .run_level (run_level)
    );

    // Behavioural reference state
    bit    m_pend [N];
    bit    m_act  [N];
    int    m_arr  [N];
    int    m_cnt;
    int    st_lvl [$];
    int    st_id  [$];

    int    checks = 0;
    int    failures = 0;
    string tag = "R1";
    bit    done = 1'b0;

    function automatic logic [N-1:0] bitv(input int i);
        logic [N-1:0] v;
        v = '0;
        v[i] = 1'b1;
        return v;
    endfunction

    task automatic m_eval(output bit r, output int id, output int pre, output int lvl);
        int best, bn, ba, np;
        best = -1; bn = 0; ba = 0;
        for (int i = 0; i < N; i++) begin
            if (m_pend[i] && src_en[i] && !m_act[i]) begin
                int n;
                n = int'(prio_b[i][7:4]);
                if (best < 0 || n < bn || (n == bn && m_arr[i] < ba)) begin
                    best = i; bn = n; ba = m_arr[i];
                end
            end
        end
        np = 7 - int'(group_sel);
        if (np > 4) np = 4;
        lvl = (st_lvl.size() == 0) ? 16 : st_lvl[$];
        id  = (best < 0) ? 0 : best;
        pre = bn >> (4 - np);
        r   = (best >= 0) && (pre < lvl);
    endtask

    task automatic m_update(input logic [N-1:0] sv, input bit a, input bit e,
                            input bit r, input int id, input int pre);
        bit any_new;
        if (e) begin
            if (st_lvl.size() > 0) begin
                m_act[st_id[$]] = 1'b0;
                void'(st_lvl.pop_back());
                void'(st_id.pop_back());
            end
        end else if (a && r) begin
            m_pend[id] = 1'b0;
            m_act[id]  = 1'b1;
            st_lvl.push_back(pre);
            st_id.push_back(id);
        end
        any_new = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (sv[i] && !m_pend[i]) begin
                m_pend[i] = 1'b1;
                m_arr[i]  = m_cnt;
                any_new   = 1'b1;
            end
        end
        if (any_new) m_cnt++;
    endtask

    task automatic step(input logic [N-1:0] sv, input bit a, input bit e);
        bit er;
        int eid, epre, elvl;
        @(negedge clk);
        irq_set = sv; ack = a; eoi = e;
        #1;
        m_eval(er, eid, epre, elvl);
        checks++;
        if (irq_req !== er || irq_id !== 6'(eid) || run_level !== 5'(elvl)) begin
            failures++;
            $display("FAIL %s: req=%0b id=%0d level=%0d, expected req=%0b id=%0d level=%0d",
                     tag, irq_req, irq_id, run_level, er, eid, elvl);
        end
        @(posedge clk);
        m_update(sv, a, e, er, eid, epre);
    endtask

    task automatic drain();
        for (int k = 0; k < 300; k++) begin
            bit er;
            int eid, epre, elvl;
            m_eval(er, eid, epre, elvl);
            if (er)                        step('0, 1'b1, 1'b0);
            else if (st_lvl.size() > 0)    step('0, 1'b0, 1'b1);
            else                           break;
        end
        step('0, 1'b0, 1'b0);
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    initial begin
        for (int i = 0; i < N; i++) begin
            prio_b[i] = {4'((i * 7) % 16), 4'((i * 3) % 16)};
            m_pend[i] = 1'b0; m_act[i] = 1'b0; m_arr[i] = 0;
        end
        m_cnt = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 / R8: idle state after reset
        tag = "R1"; step('0, 0, 0); step('0, 0, 0);
        tag = "R8"; step('0, 0, 0);
        src_en = '1;

        // R2: disabled source stays pending and is not requested
        tag = "R2"; src_en[4] = 1'b0;
        step(bitv(4), 0, 0); step('0, 0, 0);
        tag = "R9"; step('0, 1, 0); step('0, 0, 0);
        tag = "R2"; src_en[4] = 1'b1; step('0, 0, 0);
        tag = "R9"; step('0, 1, 0); step('0, 0, 0);
        tag = "R10"; step('0, 0, 1); step('0, 0, 0);
        drain();

        // R3 / R4 / R12: value order, low field bits ignored
        prio_b[10] = 8'h7F; prio_b[11] = 8'h70; prio_b[12] = 8'h52;
        tag = "R3"; step(bitv(10) | bitv(11) | bitv(12), 0, 0); step('0, 0, 0);
        tag = "R4"; step('0, 1, 0);
        tag = "R12"; step('0, 0, 0);
        tag = "R3"; step('0, 0, 1); step('0, 0, 0);
        drain();

        // R5: arrival order, then number order
        prio_b[30] = 8'h60; prio_b[20] = 8'h60; prio_b[41] = 8'h60; prio_b[40] = 8'h60;
        tag = "R5"; step(bitv(30), 0, 0); step(bitv(20), 0, 0); step('0, 0, 0);
        step(bitv(41) | bitv(40), 0, 0); step('0, 1, 0); step('0, 0, 0);
        step('0, 1, 0); step('0, 0, 0);
        drain();

        // R6 / R7: grouping sweep with preempting and sub-only candidates
        prio_b[40] = 8'h83; prio_b[41] = 8'h4C; prio_b[42] = 8'h91;
        for (int g = 0; g < 8; g++) begin
            group_sel = 3'(g);
            tag = "R6"; step(bitv(40), 0, 0); step('0, 1, 0);
            step(bitv(42), 0, 0); step('0, 0, 0);
            tag = "R7"; step('0, 1, 0); step(bitv(41), 0, 0); step('0, 0, 0);
            step('0, 1, 0); step('0, 0, 0);
            drain();
        end
        group_sel = 3'd4;

        // R11: active source re-pended is held back until retired
        prio_b[50] = 8'h20;
        tag = "R11"; step(bitv(50), 0, 0); step('0, 1, 0);
        step(bitv(50), 0, 0); step('0, 0, 0);
        step('0, 0, 1); step('0, 0, 0);
        drain();

        // R10: empty pop and ack/eoi collision
        tag = "R10"; step('0, 0, 1); step('0, 0, 0);
        step(bitv(3), 0, 0); step('0, 1, 1); step('0, 0, 0);
        drain();

        // Mixed traffic
        tag = "R12";
        for (int k = 0; k < 400; k++) begin
            logic [N-1:0] sv;
            sv = '0;
            for (int i = 0; i < N; i++) if ($urandom_range(39) == 0) sv[i] = 1'b1;
            if (k % 50 == 25) src_en[$urandom_range(N-1)] ^= 1'b1;
            step(sv, $urandom_range(2) == 0, $urandom_range(3) == 0);
        end
        src_en = '1;
        drain();

        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: run did not end, expected completion");
            summary();
            $finish;
        end
    end

endmodule